// File: doc/BRIEF.md
# Switching-Activity Noise State Machine

This block is a small free-running state machine that exists to draw supply current that changes strongly from one clock cycle to the next. It walks a fixed loop of eight 4-bit state codes. The codes are neither binary nor Gray: they are placed so that the number of state bits that toggle on each step swings between one and four. Many copies can sit beside a sensitive datapath, and the toggling of their flip-flops adds a deterministic but data-independent current pattern.

The next-state logic reads its inputs only when the machine is being initialized. A synchronous reset forces the first code of the loop. A load strobe starts the machine at any code of the loop; codes outside the loop are refused. An enable input freezes the machine, so a disabled unit draws no switching current. The current state and the number of bits that flipped on the most recent clock edge are brought out so that the toggle pattern can be checked.

Top module: `noise_fsm_unit`

## Requirements
- R1: Once reset has been applied, the 4-bit state output only ever holds one of the eight loop codes 0000, 1111, 1110, 0001, 0111, 0110, 1001, 1000.
- R2: With `srst` high at a clock edge, the state becomes 0000 and the flip count becomes 0 after that edge, whatever `load`, `load_code` and `en` are.
- R3: With `srst` low and `load` high, a `load_code` equal to one of the loop codes is the state after the edge, whether `en` is high or low.
- R4: With `srst` low and `load` high, a `load_code` that is not a loop code leaves the state unchanged at that edge, and the flip count reads 0.
- R5: With `srst` and `load` low and `en` high, each edge moves the state to the next code in the loop order 0000, 1111, 1110, 0001, 0111, 0110, 1001, 1000, and from 1000 back to 0000.
- R6: With `srst` and `load` low and `en` low, the state holds and the flip count reads 0.
- R7: `flip_cnt` equals the number of state bits that changed at the most recent clock edge; around the loop it reads 4, 1, 4, 2, 1, 4, 1, 1.
- R8: While `load` is low, the value on `load_code` has no effect on the state sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; low freezes the state |
| load | input | 1 | Initialize strobe, takes `load_code` if it is a loop code |
| load_code | input | 4 | State code to start from |
| state_q | output | 4 | Current state code |
| flip_cnt | output | 3 | Bits toggled at the most recent edge |

## Verification
The bench builds the block with its default parameters, a 4-bit state and an eight-entry loop, which puts every loop code and all sixteen possible load values within reach of the random stimulus. Randomly mixed reset, load, enable and garbage `load_code` values exercise the priority between reset, load and stepping, while directed runs walk the whole loop to check the order and the toggle counts, including the wrap from the last code to the first. Loads of each refused code confirm that an invalid value neither moves nor steps the machine.

// File: rtl/noise_fsm_pkg.sv
package noise_fsm_pkg;

  localparam int STATE_W  = 4;
  localparam int LOOP_LEN = 8;
  localparam int CNT_W    = $clog2(STATE_W + 1);

  typedef logic [STATE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // Codes of the loop, in visiting order.
  function automatic code_t loop_code(input int idx);
    case (idx)
      0:       return 4'b0000;
      1:       return 4'b1111;
      2:       return 4'b1110;
      3:       return 4'b0001;
      4:       return 4'b0111;
      5:       return 4'b0110;
      6:       return 4'b1001;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic is_loop_code(input code_t c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LOOP_LEN; i++) begin
      if (c == loop_code(i)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/noise_fsm_next.sv
module noise_fsm_next
  import noise_fsm_pkg::*;
#(
  parameter int W = STATE_W,
  parameter int N = LOOP_LEN
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load_code,
  output logic [W-1:0] succ,
  output logic         load_valid,
  output logic         cur_valid
);

  logic [N-1:0]        match;
  logic [N-1:0]        load_hit;
  logic [N-1:0][W-1:0] succ_tab;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign match[g]    = (cur == loop_code(g));
    assign load_hit[g] = (load_code == loop_code(g));
    assign succ_tab[g] = loop_code((g + 1) % N);
  end

  always_comb begin
    succ = loop_code(0);
    for (int i = 0; i < N; i++) begin
      if (match[i]) succ = succ_tab[i];
    end
  end

  assign load_valid = |load_hit;
  assign cur_valid  = |match;

endmodule

// File: rtl/noise_flip_count.sv
module noise_flip_count
  import noise_fsm_pkg::*;
#(
  parameter int W  = STATE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [W-1:0]  cur,
  output logic [CW-1:0] flips
);

  logic [W-1:0] prev_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk) begin
    if (srst) prev_q <= '0;
    else      prev_q <= cur;
  end

  assign diff = cur ^ prev_q;

  always_comb begin
    flips = '0;
    for (int i = 0; i < W; i++) flips = flips + CW'(diff[i]);
  end

  assert_flip_bound_R7: assert property (@(posedge clk) disable iff (srst)
    flips <= CW'(W));

endmodule

// File: rtl/noise_fsm_unit.sv
module noise_fsm_unit
  import noise_fsm_pkg::*;
(
  input  logic               clk,
  input  logic               srst,
  input  logic               en,
  input  logic               load,
  input  logic [STATE_W-1:0] load_code,
  output logic [STATE_W-1:0] state_q,
  output logic [CNT_W-1:0]   flip_cnt
);

  logic [STATE_W-1:0] succ;
  logic               load_valid;
  logic               cur_valid;

  noise_fsm_next #(.W(STATE_W), .N(LOOP_LEN)) u_next (
    .cur        (state_q),
    .load_code  (load_code),
    .succ       (succ),
    .load_valid (load_valid),
    .cur_valid  (cur_valid)
  );

  always_ff @(posedge clk) begin
    if (srst)                state_q <= loop_code(0);
    else if (load)           state_q <= load_valid ? load_code : state_q;
    else if (en)             state_q <= succ;
  end

  noise_flip_count #(.W(STATE_W), .CW(CNT_W)) u_flips (
    .clk   (clk),
    .srst  (srst),
    .cur   (state_q),
    .flips (flip_cnt)
  );

  assert_loop_only_R1: assert property (@(posedge clk) disable iff (srst)
    cur_valid);

  assert_reset_first_R2: assert property (@(posedge clk)
    srst |=> (state_q == '0) && (flip_cnt == '0));

  assert_good_load_R3: assert property (@(posedge clk) disable iff (srst)
    (load && is_loop_code(load_code)) |=> state_q == $past(load_code));

  assert_bad_load_R4: assert property (@(posedge clk) disable iff (srst)
    (load && !is_loop_code(load_code)) |=> $stable(state_q) && flip_cnt == '0);

  assert_step_moves_R5: assert property (@(posedge clk) disable iff (srst)
    (!load && en) |=> flip_cnt != '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (srst)
    (!load && !en) |=> $stable(state_q));

endmodule

// File: tb/noise_fsm_unit_bench.sv
module noise_fsm_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       srst, en, load;
  logic [3:0] load_code;
  logic [3:0] state_q;
  logic [2:0] flip_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] m_state;
  logic [2:0] m_flips;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_fsm_unit u_noise_fsm_unit (
    .clk(clk), .srst(srst), .en(en), .load(load),
    .load_code(load_code), .state_q(state_q), .flip_cnt(flip_cnt)
  );

  function automatic logic [3:0] b_next(input logic [3:0] s);
    case (s)
      4'b0000: return 4'b1111;
      4'b1111: return 4'b1110;
      4'b1110: return 4'b0001;
      4'b0001: return 4'b0111;
      4'b0111: return 4'b0110;
      4'b0110: return 4'b1001;
      4'b1001: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic b_valid(input logic [3:0] c);
    return c inside {4'b0000, 4'b1111, 4'b1110, 4'b0001,
                     4'b0111, 4'b0110, 4'b1001, 4'b1000};
  endfunction

  function automatic logic [2:0] b_pop(input logic [3:0] v);
    return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction

  task automatic check(input string req, input logic [3:0] exp_s, input logic [2:0] exp_f);
    n_tests++;
    if (state_q !== exp_s || flip_cnt !== exp_f) begin
      n_fail++;
      $display("FAIL %s: state=%b flips=%0d expected state=%b flips=%0d",
               req, state_q, flip_cnt, exp_s, exp_f);
    end
  endtask

  // Drive at negedge, update model, wait for posedge, check at next negedge.
  task automatic cycle(input logic r, input logic e, input logic l,
                       input logic [3:0] c, input string req);
    logic [3:0] nxt;
    srst = r; en = e; load = l; load_code = c;
    if (r)                     nxt = 4'b0000;
    else if (l)                nxt = b_valid(c) ? c : m_state;
    else if (e)                nxt = b_next(m_state);
    else                       nxt = m_state;
    m_flips = r ? 3'd0 : b_pop(nxt ^ m_state);
    m_state = nxt;
    @(negedge clk);
    check(req, m_state, m_flips);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    srst = 1'b1; en = 1'b0; load = 1'b0; load_code = 4'h0;
    m_state = 4'h0; m_flips = 3'd0;
    @(negedge clk);
    cycle(1'b1, 1'b1, 1'b1, 4'b1111, "R2 reset over load");

    // R5 / R7: walk the full loop twice, including the wrap.
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, 1'b0, 4'(i), "R5 R7 R8 loop walk");

    // R6: hold while disabled.
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, 4'hA, "R6 hold");

    // R3: every loop code loads, with enable low.
    foreach (m_flips[i]) begin end
    for (int i = 0; i < 16; i++)
      if (b_valid(4'(i))) cycle(1'b0, 1'b0, 1'b1, 4'(i), "R3 load valid");

    // R4: every refused code, with enable high.
    for (int i = 0; i < 16; i++)
      if (!b_valid(4'(i))) cycle(1'b0, 1'b1, 1'b1, 4'(i), "R4 load invalid");

    // R2: reset from a mid-loop state.
    cycle(1'b0, 1'b0, 1'b1, 4'b0110, "R3 load mid");
    cycle(1'b1, 1'b0, 1'b0, 4'b0000, "R2 reset");

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic r, e, l;
      r = ($urandom % 20) == 0;
      l = ($urandom % 5) == 0;
      e = ($urandom % 4) != 0;
      cycle(r, e, l, 4'($urandom), "R1 R3 R4 R5 R6 R7 R8 random");
      n_tests++;
      if (!b_valid(state_q)) begin
        n_fail++;
        $display("FAIL R1: state=%b expected a loop code", state_q);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule